// File: doc/BRIEF.md
# Timed Self-Clearing Reset Sequencer

This block drives the reset of one peripheral from a request bit that software writes. When a request is taken, the block holds the peripheral in reset with its clock gated for a programmable number of ticks. It then removes the reset and keeps the clock gated for a second programmable number of ticks. After that it turns the clock back on, clears the request bit by itself and sets a sticky completion flag. Software clears that flag by writing 1 to it.

Both hold times are counted in ticks of 0.25 µs. A prescaler turns system clocks into ticks; the parameter `TICK_DIV` gives the number of clocks per tick, for example 25 at 100 MHz. Each hold field is `HOLD_W` bits wide. A 4-bit field reaches 3.75 µs per phase and an 8-bit field reaches 63.75 µs, so a full sequence can take up to twice that. Software clears a stale completion flag, writes the request bit, and then polls for the flag.

The controller has four states: `ST_IDLE`, `ST_ASSERT_HOLD`, `ST_RELEASE_HOLD` and `ST_DONE`. It moves through them as follows:
- **Start:** `ST_IDLE` goes to `ST_ASSERT_HOLD` when a request is accepted.
- **Reset released:** `ST_ASSERT_HOLD` goes to `ST_RELEASE_HOLD` when its hold count runs out.
- **Clock restored:** `ST_RELEASE_HOLD` goes to `ST_DONE` when its hold count runs out.
- **Finish:** `ST_DONE` goes to `ST_IDLE` unconditionally after one cycle.

Top module: `rst_seq_chan`

## Requirements
- R1: After reset the block is in `ST_IDLE`. In that state `reset_out` is 0, `clk_en_out` is 1, `done_out` is 0, and the control register (address 0) reads 0.
- R2: Control register, address 0: bit 0 is the request bit. Writing 1 to bit 0 starts a sequence. Bit 0 reads 1 from the cycle after an accepted request until the sequence returns to `ST_IDLE`, and it then reads 0 without any write from software.
- R3: Hold register, address 1: bits [HOLD_W-1:0] hold the assert time A. In `ST_ASSERT_HOLD`, `reset_out` is 1 and `clk_en_out` is 0, for exactly A*TICK_DIV+1 cycles.
- R4: Hold register bits [2*HOLD_W-1:HOLD_W] hold the release time R. In `ST_RELEASE_HOLD`, `reset_out` is 0 and `clk_en_out` stays 0, for exactly R*TICK_DIV+1 cycles.
- R5: In `ST_DONE`, `clk_en_out` returns to 1 with `reset_out` at 0. One cycle later `done_out` and control bit 1 read 1, and control bit 0 reads 0.
- R6: A hold value of zero makes that phase last a single cycle. The sequence still passes through every state and still sets the done flag.
- R7: A request written while a sequence is running is ignored. No second sequence follows the first one.
- R8: A request written while the done flag is set is ignored. The block stays in `ST_IDLE` with `reset_out` at 0.
- R9: The done flag (`done_out`, control bit 1) stays set until 1 is written to control bit 1; writing 0 there leaves it set. If the flag is set in the same cycle as a clear, the set wins.
- R10: The hold register reads back the value last written to it.
- R11: `reset_out` is never 1 while `clk_en_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 hold times) |
| wr_data | input | 2*HOLD_W | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 2*HOLD_W | Read data for `rd_addr`, combinational |
| reset_out | output | 1 | Peripheral reset, active high |
| clk_en_out | output | 1 | Peripheral clock enable |
| done_out | output | 1 | Sticky sequence-complete flag |

## Verification
The bench builds the block with `TICK_DIV=3` and `HOLD_W=4`. With these values even the largest hold fields (15 ticks in each phase) finish in under a hundred cycles. This makes it cheap to measure exact phase lengths for zero, small and maximum hold values. It also makes it cheap to test a request written in the middle of a running hold and a request written while the done flag is still set.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE         = 2'd0,
        ST_ASSERT_HOLD  = 2'd1,
        ST_RELEASE_HOLD = 2'd2,
        ST_DONE         = 2'd3
    } rsq_state_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_HOLD = 1'b1;
    localparam int   CTRL_REQ_BIT  = 0;
    localparam int   CTRL_DONE_BIT = 1;
endpackage

// File: rtl/rsq_prescaler.sv
module rsq_prescaler #(
    parameter int TICK_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = $clog2(TICK_DIV + 1);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsq_hold_timer.sv
module rsq_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              tick,
    output logic              expired
);
    logic [HOLD_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              done_flag,
    input  logic              expired,
    input  logic [HOLD_W-1:0] assert_hold,
    input  logic [HOLD_W-1:0] release_hold,
    output logic              load,
    output logic [HOLD_W-1:0] load_val,
    output logic              reset_out,
    output logic              clk_en_out,
    output logic              busy,
    output logic              set_done
);
    rsq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = assert_hold;
        unique case (state_q)
            ST_IDLE: begin
                if (req_wr && !done_flag) begin
                    state_d = ST_ASSERT_HOLD;
                    load    = 1'b1;
                end
            end
            ST_ASSERT_HOLD: begin
                if (expired) begin
                    state_d  = ST_RELEASE_HOLD;
                    load     = 1'b1;
                    load_val = release_hold;
                end
            end
            ST_RELEASE_HOLD: begin
                if (expired) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        reset_out  = 1'b0;
        clk_en_out = 1'b1;
        busy       = 1'b1;
        set_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:         busy = 1'b0;
            ST_ASSERT_HOLD: begin
                reset_out  = 1'b1;
                clk_en_out = 1'b0;
            end
            ST_RELEASE_HOLD: clk_en_out = 1'b0;
            ST_DONE:         set_done = 1'b1;
            default:         busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/rst_seq_chan.sv
module rst_seq_chan
    import rsq_pkg::*;
#(
    parameter int TICK_DIV = 25,
    parameter int HOLD_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [2*HOLD_W-1:0]   wr_data,
    input  logic                  rd_addr,
    output logic [2*HOLD_W-1:0]   rd_data,
    output logic                  reset_out,
    output logic                  clk_en_out,
    output logic                  done_out
);
    localparam int DATA_W = 2 * HOLD_W;

    logic [DATA_W-1:0] hold_q;
    logic              done_q;
    logic              req_wr, clr_wr;
    logic              load, tick, expired, busy, set_done;
    logic [HOLD_W-1:0] load_val;

    assign req_wr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_REQ_BIT];
    assign clr_wr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_DONE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en && (wr_addr == ADDR_HOLD)) begin
            hold_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (set_done) begin
            done_q <= 1'b1;
        end else if (clr_wr) begin
            done_q <= 1'b0;
        end
    end

    rsq_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_wr       (req_wr),
        .done_flag    (done_q),
        .expired      (expired),
        .assert_hold  (hold_q[HOLD_W-1:0]),
        .release_hold (hold_q[DATA_W-1:HOLD_W]),
        .load         (load),
        .load_val     (load_val),
        .reset_out    (reset_out),
        .clk_en_out   (clk_en_out),
        .busy         (busy),
        .set_done     (set_done)
    );

    rsq_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick)
    );

    rsq_hold_timer #(.HOLD_W(HOLD_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .expired  (expired)
    );

    assign done_out = done_q;
    assign rd_data  = (rd_addr == ADDR_HOLD) ? hold_q : DATA_W'({done_q, busy});
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
    input logic clk,
    input logic rst_n,
    input logic reset_out,
    input logic clk_en_out,
    input logic done_out,
    input logic clr_wr
);
    p_gated_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |-> !clk_en_out);

    p_release_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_out) |-> !clk_en_out);

    p_done_after_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_out) |-> ($past(clk_en_out) && !reset_out));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_out && !clr_wr) |=> done_out);

    p_no_start_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_out && !reset_out && clk_en_out) |=> !reset_out);
endmodule

bind rst_seq_chan rsq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_out  (reset_out),
    .clk_en_out (clk_en_out),
    .done_out   (done_out),
    .clr_wr     (wr_en && (wr_addr == 1'b0) && wr_data[1])
);

// File: tb/sim_rst_seq_chan.sv
`timescale 1ns/1ps
module sim_rst_seq_chan;
    localparam int TD = 3;
    localparam int HW = 4;
    localparam int DW = 2 * HW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_addr = 1'b0;
    logic [DW-1:0] rd_data;
    logic reset_out, clk_en_out, done_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rst_seq_chan #(.TICK_DIV(TD), .HOLD_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .reset_out(reset_out), .clk_en_out(clk_en_out), .done_out(done_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Starts a sequence and measures both phases; leaves done set.
    task automatic run_seq(input int a, input int r, input string tag);
        int n_rst = 0, n_gate = 0, n_busy = 0, n_cyc = 0;
        wr(1'b1, DW'((r << HW) | a));
        rd_addr = 1'b0;
        wr(1'b0, DW'(1));
        while (!done_out && n_cyc < 400) begin
            if (reset_out) n_rst++;
            if (!clk_en_out) n_gate++;
            if (rd_data[0]) n_busy++;
            n_cyc++;
            @(negedge clk);
        end
        chk(n_rst == a*TD + 1, {"R3 assert hold ", tag}, n_rst, a*TD + 1);
        chk(n_gate - n_rst == r*TD + 1, {"R4 release hold ", tag}, n_gate - n_rst, r*TD + 1);
        chk(n_busy == n_cyc, {"R2 request bit while running ", tag}, n_busy, n_cyc);
        chk(done_out && clk_en_out && !reset_out, {"R5 done and clock on ", tag},
            {done_out, clk_en_out, reset_out}, 3'b110);
        chk(rd_data == DW'(2), {"R2 R5 control readback ", tag}, rd_data, 2);
    endtask

    task automatic clear_done(input string req);
        wr(1'b0, DW'(2));
        chk(!done_out && rd_data == '0, req, done_out, 0);
    endtask

    task automatic t_reset();
        rd_addr = 1'b0;
        #1;
        chk(!reset_out && clk_en_out && !done_out && rd_data == '0,
            "R1 reset state", {reset_out, clk_en_out, done_out}, 3'b010);
    endtask

    task automatic t_readback();
        wr(1'b1, DW'(8'hA5));
        rd_addr = 1'b1;
        #1;
        chk(rd_data == DW'(8'hA5), "R10 hold readback", rd_data, 8'hA5);
        rd_addr = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int n_start = 0;
        wr(1'b1, DW'((2 << HW) | 2));
        wr(1'b0, DW'(1));
        repeat (2) @(negedge clk);
        wr(1'b0, DW'(1));
        while (!done_out) @(negedge clk);
        clear_done("R9 clear before idle watch");
        for (int i = 0; i < 30; i++) begin
            if (reset_out || rd_data[0]) n_start++;
            @(negedge clk);
        end
        chk(n_start == 0, "R7 request while running ignored", n_start, 0);
    endtask

    task automatic t_done_blocks();
        int n_start = 0;
        run_seq(1, 1, "pre-R8");
        wr(1'b0, DW'(1));
        for (int i = 0; i < 12; i++) begin
            if (reset_out || rd_data[0]) n_start++;
            @(negedge clk);
        end
        chk(n_start == 0 && done_out, "R8 request while done ignored", n_start, 0);
    endtask

    task automatic t_w1c();
        wr(1'b0, DW'(0));
        chk(done_out == 1'b1, "R9 write 0 keeps done", done_out, 1);
        clear_done("R9 write 1 clears done");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        run_seq(2, 3, "a2 r3");
        clear_done("R9 clear after a2 r3");
        run_seq(0, 0, "R6 zero holds");
        clear_done("R9 clear after zero");
        run_seq(0, 4, "R6 zero assert");
        clear_done("R9 clear after zero assert");
        run_seq(15, 15, "max holds");
        clear_done("R9 clear after max");
        t_busy_ignore();
        t_done_blocks();
        t_w1c();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule